// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 64 external interrupt lines into one request line for a processor. Software programs each line as sensitive to a low level, a high level, a falling edge or a rising edge. It also gives each line an urgency value from 0 to 255, where 0 keeps the line silent. A global urgency floor and a global on/off bit gate what reaches the processor. Line 0 is reserved and never takes part.

Every raw line passes through a two-flop synchronizer. Edge-sensitive lines set a sticky latch, which stays set until software clears it with a coded write. A tree arbiter picks the line with the greatest urgency. When several lines share that urgency, the lowest-numbered line wins. The result is registered, and the processor reads it back from a status word that carries the winner's number and an "idle" flag.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the request output is 0. The status word reads 0x0001_0000. The control, floor, mode and urgency registers all read 0.
- R2: Mode code 00 treats a line as active while it is low, and code 01 treats it as active while it is high. A level-mode line competes only while it is active.
- R3: Mode code 10 latches a falling edge and code 11 latches a rising edge of the synchronized line. The latch keeps the line pending after the input returns, and the opposite edge does not set it.
- R4: A write to the edge-clear word at word address 0x03 addresses lines 0–31, and the word at 0x04 addresses lines 32–63. In that word, bit 8 enables a clear of index bits 3:0 within the lower 16 lines of the half. Bit 24 enables a clear of index bits 19:16 within the upper 16 lines. Without its enable bit the index has no effect, and other latches are untouched.
- R5: A pending line competes only when its urgency is strictly greater than the floor, which is held in bits 7:0 at address 0x01. Urgency 0 therefore never competes.
- R6: Bit 0 at address 0x00 is the global enable. While it is 0, the request output is 0 and the status reads idle.
- R7: Among competing lines, the greatest urgency wins. On a tie, the lowest line number wins.
- R8: The status word at address 0x02 holds the winning line number in bits 5:0 and is 0 elsewhere. When nothing competes, it reads exactly 0x0001_0000 (bit 16 set, number 0). The request output is 1 exactly when the idle flag is 0.
- R9: Line 0 never wins, whatever its input, mode or urgency.
- R10: Mode words at 0x08–0x0B hold sixteen 2-bit fields each. Line n sits in word n/16 at bits 2*(n%16)+1:2*(n%16). Urgency words at 0x10–0x1F hold four byte lanes each, with line n in word n/4, byte n%4. All of these read back as written. The clear words and unmapped addresses read 0.
- R11: A level change on an input reaches the request output and status after the third rising clock edge, and not before. A register write takes effect at the second edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 6 | Word address of the register access |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| irq_src_i | input | NUM_SRC | Raw interrupt lines, asynchronous |
| cpu_irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions assume that each write strobe lasts one cycle. They also assume that no edge-clear write names more than one line per 16-line group, which the write format itself guarantees. They further assume that raw lines may change at any time, because the synchronizer absorbs this. The stimulus drives every bus and line change on the falling clock edge, so each register and latch sees a stable value at the rising edge. Edge-mode lines are exercised only in directed sequences with long settle gaps, while the pseudo-random sweeps keep every line in a level mode so that the arithmetic model in the bench stays exact.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned AW = 6;
  localparam int unsigned DW = 32;
  localparam int unsigned LW = 8;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  localparam logic [AW-1:0] A_CTRL      = 6'h00;
  localparam logic [AW-1:0] A_THRESH    = 6'h01;
  localparam logic [AW-1:0] A_STATUS    = 6'h02;
  localparam logic [AW-1:0] A_ECLR_LO   = 6'h03;
  localparam logic [AW-1:0] A_MODE_BASE = 6'h08;
  localparam logic [AW-1:0] A_LVL_BASE  = 6'h10;

  localparam int unsigned IDLE_BIT = 16;

endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [AW-1:0]               addr_i,
  input  logic [DW-1:0]               wdata_i,
  input  logic                        we_i,
  output logic [DW-1:0]               rdata_o,
  input  logic [IDX_W-1:0]            win_i,
  input  logic                        idle_i,
  output logic                        en_o,
  output logic [LW-1:0]               thr_o,
  output logic [NUM_SRC-1:0][1:0]     mode_o,
  output logic [NUM_SRC-1:0][LW-1:0]  lvl_o,
  output logic [NUM_SRC-1:0]          clr_o
);

  localparam int MODE_REGS = NUM_SRC / 16;
  localparam int LVL_REGS  = NUM_SRC / 4;
  localparam int HALVES    = NUM_SRC / 32;

  logic                       en_q, en_d;
  logic [LW-1:0]              thr_q, thr_d;
  logic [NUM_SRC-1:0][1:0]    mode_q, mode_d;
  logic [NUM_SRC-1:0][LW-1:0] lvl_q, lvl_d;
  logic [NUM_SRC-1:0]         clr;

  // next-state of the programmable fields
  always_comb begin
    en_d   = en_q;
    thr_d  = thr_q;
    mode_d = mode_q;
    lvl_d  = lvl_q;
    if (we_i) begin
      if (addr_i == A_CTRL)   en_d  = wdata_i[0];
      if (addr_i == A_THRESH) thr_d = wdata_i[LW-1:0];
      for (int r = 0; r < MODE_REGS; r++) begin
        if (addr_i == A_MODE_BASE + AW'(r)) begin
          for (int f = 0; f < 16; f++) mode_d[16*r+f] = wdata_i[2*f +: 2];
        end
      end
      for (int r = 0; r < LVL_REGS; r++) begin
        if (addr_i == A_LVL_BASE + AW'(r)) begin
          for (int b = 0; b < 4; b++) lvl_d[4*r+b] = wdata_i[8*b +: 8];
        end
      end
    end
  end

  // edge-latch clear decode: one pulse per enabled 16-line group
  always_comb begin
    clr = '0;
    for (int h = 0; h < HALVES; h++) begin
      if (we_i && (addr_i == A_ECLR_LO + AW'(h))) begin
        for (int g = 0; g < 2; g++) begin
          if (wdata_i[16*g+8]) clr[32*h+16*g+int'(wdata_i[16*g +: 4])] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      thr_q  <= '0;
      mode_q <= '0;
      lvl_q  <= '0;
    end else begin
      en_q   <= en_d;
      thr_q  <= thr_d;
      mode_q <= mode_d;
      lvl_q  <= lvl_d;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)   rdata_o[0] = en_q;
    if (addr_i == A_THRESH) rdata_o[LW-1:0] = thr_q;
    if (addr_i == A_STATUS) begin
      rdata_o[IDX_W-1:0] = win_i;
      rdata_o[IDLE_BIT]  = idle_i;
    end
    for (int r = 0; r < MODE_REGS; r++) begin
      if (addr_i == A_MODE_BASE + AW'(r)) begin
        for (int f = 0; f < 16; f++) rdata_o[2*f +: 2] = mode_q[16*r+f];
      end
    end
    for (int r = 0; r < LVL_REGS; r++) begin
      if (addr_i == A_LVL_BASE + AW'(r)) begin
        for (int b = 0; b < 4; b++) rdata_o[8*b +: 8] = lvl_q[4*r+b];
      end
    end
  end

  assign en_o   = en_q;
  assign thr_o  = thr_q;
  assign mode_o = mode_q;
  assign lvl_o  = lvl_q;
  assign clr_o  = clr;

  // R4: one coded write names at most one line per group
  a_r4_clear_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(clr_o) <= 2);

  // R4: clear pulses come only from a bus write
  a_r4_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |-> (clr_o == '0));

endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       src_i,
  input  logic [NUM_SRC-1:0][1:0]  mode_i,
  input  logic [NUM_SRC-1:0]       clr_i,
  output logic [NUM_SRC-1:0]       pend_o
);

  logic [NUM_SRC-1:0] sync1_q, sync2_q, prev_q;
  logic [NUM_SRC-1:0] lat_q, lat_d;
  logic [NUM_SRC-1:0] hit;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      logic rise, fall;
      rise   = sync2_q[i] & ~prev_q[i];
      fall   = ~sync2_q[i] & prev_q[i];
      hit[i] = mode_i[i][1] & (mode_i[i][0] ? rise : fall);
      // a fresh edge beats a clear in the same cycle
      lat_d[i] = hit[i] | (lat_q[i] & ~clr_i[i]);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      unique case (trig_e'(mode_i[i]))
        TRIG_LOW:  pend_o[i] = ~sync2_q[i];
        TRIG_HIGH: pend_o[i] = sync2_q[i];
        default:   pend_o[i] = lat_q[i];
      endcase
    end
    pend_o[0] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      lat_q   <= '0;
    end else begin
      sync1_q <= src_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      lat_q   <= lat_d;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R3: a set latch survives until a clear
    a_r3_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lat_q[i] && !clr_i[i]) |=> lat_q[i]);
    // R4: a clear with no competing edge empties the latch
    a_r4_latch_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !hit[i]) |=> !lat_q[i]);
  end

endmodule

// File: rtl/irq_ctrl_arb.sv
module irq_ctrl_arb
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]          pend_i,
  input  logic [NUM_SRC-1:0][LW-1:0]  lvl_i,
  input  logic [LW-1:0]               thr_i,
  output logic                        valid_o,
  output logic [IDX_W-1:0]            idx_o
);

  localparam int STAGES = IDX_W;

  for (genvar s = 0; s <= STAGES; s++) begin : g_st
    localparam int W = NUM_SRC >> s;
    logic [W-1:0]           v;
    logic [W-1:0][LW-1:0]   l;
    logic [W-1:0][IDX_W-1:0] x;

    if (s == 0) begin : g_leaf
      for (genvar k = 0; k < W; k++) begin : g_in
        assign v[k] = pend_i[k] & (lvl_i[k] > thr_i);
        assign l[k] = lvl_i[k];
        assign x[k] = IDX_W'(k);
      end
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_pair
        logic take_lo;
        // lower half keeps ties, so the lowest number wins on equal urgency
        assign take_lo = g_st[s-1].v[2*k] &
                         (!g_st[s-1].v[2*k+1] || (g_st[s-1].l[2*k] >= g_st[s-1].l[2*k+1]));
        assign v[k] = g_st[s-1].v[2*k] | g_st[s-1].v[2*k+1];
        assign l[k] = take_lo ? g_st[s-1].l[2*k] : g_st[s-1].l[2*k+1];
        assign x[k] = take_lo ? g_st[s-1].x[2*k] : g_st[s-1].x[2*k+1];
      end
    end
  end

  assign valid_o = g_st[STAGES].v[0];
  assign idx_o   = g_st[STAGES].x[0];

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  input  logic               bus_we_i,
  output logic [DW-1:0]      bus_rdata_o,
  input  logic [NUM_SRC-1:0] irq_src_i,
  output logic               cpu_irq_o
);

  localparam int IDX_W = $clog2(NUM_SRC);

  logic [1:0]                 rst_pipe;
  logic                       rst_n;
  logic                       ctrl_en;
  logic [LW-1:0]              thr_w;
  logic [NUM_SRC-1:0][1:0]    mode_w;
  logic [NUM_SRC-1:0][LW-1:0] lvl_w;
  logic [NUM_SRC-1:0]         clr_w;
  logic [NUM_SRC-1:0]         pend_w;
  logic                       arb_valid;
  logic [IDX_W-1:0]           arb_idx;
  logic                       irq_q, irq_d;
  logic [IDX_W-1:0]           win_q, win_d;
  logic                       idle_q, idle_d;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  irq_ctrl_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .we_i    (bus_we_i),
    .rdata_o (bus_rdata_o),
    .win_i   (win_q),
    .idle_i  (idle_q),
    .en_o    (ctrl_en),
    .thr_o   (thr_w),
    .mode_o  (mode_w),
    .lvl_o   (lvl_w),
    .clr_o   (clr_w)
  );

  irq_src_cond #(.NUM_SRC(NUM_SRC)) u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .src_i  (irq_src_i),
    .mode_i (mode_w),
    .clr_i  (clr_w),
    .pend_o (pend_w)
  );

  irq_ctrl_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .pend_i  (pend_w),
    .lvl_i   (lvl_w),
    .thr_i   (thr_w),
    .valid_o (arb_valid),
    .idx_o   (arb_idx)
  );

  // output stage next state
  always_comb begin
    irq_d  = ctrl_en & arb_valid;
    win_d  = irq_d ? arb_idx : '0;
    idle_d = ~irq_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      win_q  <= '0;
      idle_q <= 1'b1;
    end else begin
      irq_q  <= irq_d;
      win_q  <= win_d;
      idle_q <= idle_d;
    end
  end

  assign cpu_irq_o = irq_q;

  // R6: global enable off silences the request on the next edge
  a_r6_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ctrl_en |=> !cpu_irq_o);

  // R5: the tree only selects a line that is pending and above the floor
  a_r5_winner_eligible: assert property (@(posedge clk_i) disable iff (!rst_n)
    arb_valid |-> (pend_w[arb_idx] && (lvl_w[arb_idx] > thr_w)));

  // R9: the reserved line never wins
  a_r9_src0_excluded: assert property (@(posedge clk_i) disable iff (!rst_n)
    arb_valid |-> (arb_idx != '0));

  // R7: no competitor beats the tree result, on urgency or on number
  always @(posedge clk_i) begin
    if (rst_n && arb_valid) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (pend_w[i] && (lvl_w[i] > thr_w)) begin
          a_r7_no_better: assert ((lvl_w[i] < lvl_w[arb_idx]) ||
                                  ((lvl_w[i] == lvl_w[arb_idx]) && (IDX_W'(i) >= arb_idx)));
        end
      end
    end
  end

endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;

  logic        clk;
  logic        rst_n;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic        we;
  logic [31:0] rdata;
  logic [63:0] src;
  logic        irq;

  integer n_vec = 0;
  integer n_bad = 0;
  bit     done  = 0;

  logic [1:0]  sh_mode [64];
  logic [7:0]  sh_lvl  [64];
  logic [7:0]  sh_thr;
  logic        sh_en;
  logic [63:0] lfsr;

  localparam logic [31:0] IDLE = 32'h0001_0000;

  irq_prio_ctrl #(.NUM_SRC(64)) i_irq_prio_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_we_i    (we),
    .bus_rdata_o (rdata),
    .irq_src_i   (src),
    .cpu_irq_o   (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_cfg();
    for (int r = 0; r < 4; r++) begin
      logic [31:0] w;
      for (int f = 0; f < 16; f++) w[2*f +: 2] = sh_mode[16*r+f];
      wr(6'h08 + 6'(r), w);
    end
    for (int r = 0; r < 16; r++) begin
      logic [31:0] w;
      for (int b = 0; b < 4; b++) w[8*b +: 8] = sh_lvl[4*r+b];
      wr(6'h10 + 6'(r), w);
    end
  endtask

  // expected status from the requirements (level modes only)
  function automatic logic [31:0] model();
    int best = -1;
    for (int i = 1; i < 64; i++) begin
      logic act;
      act = (sh_mode[i] == 2'b00) ? !src[i] : (sh_mode[i] == 2'b01) ? src[i] : 1'b0;
      if (sh_en && act && (sh_lvl[i] > sh_thr)) begin
        if (best < 0) best = i;
        else if (sh_lvl[i] > sh_lvl[best]) best = i;
      end
    end
    return (best < 0) ? IDLE : 32'(best);
  endfunction

  task automatic chk_state(input string rq);
    logic [31:0] st, e;
    rd(6'h02, st);
    e = model();
    chk(rq, st, e);
    chk(rq, 32'(irq), 32'(e == IDLE ? 1'b0 : 1'b1));
  endtask

  task automatic chk_status(input string rq, input logic [31:0] e);
    logic [31:0] st;
    rd(6'h02, st);
    chk(rq, st, e);
    chk(rq, 32'(irq), 32'(e == IDLE ? 1'b0 : 1'b1));
  endtask

  task automatic next_lfsr();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; src = '1;
    lfsr = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 64; i++) begin sh_mode[i] = 2'b00; sh_lvl[i] = 8'd0; end
    sh_thr = 8'd0; sh_en = 1'b0;
    settle(5);
    rst_n = 1'b1;
    settle(4);

    // R1 reset state
    chk_status("R1 status", IDLE);
    rd(6'h00, d); chk("R1 ctrl", d, 32'd0);
    rd(6'h01, d); chk("R1 thresh", d, 32'd0);
    for (int r = 0; r < 4; r++)  begin rd(6'h08 + 6'(r), d); chk("R1 mode", d, 32'd0); end
    for (int r = 0; r < 16; r++) begin rd(6'h10 + 6'(r), d); chk("R1 level", d, 32'd0); end

    // R10 readback of the field layout
    for (int r = 0; r < 16; r++) wr(6'h10 + 6'(r), 32'h0302_0100 + 32'(r) * 32'h0404_0404);
    for (int r = 0; r < 16; r++) begin
      rd(6'h10 + 6'(r), d);
      chk("R10 level lanes", d, 32'h0302_0100 + 32'(r) * 32'h0404_0404);
    end
    for (int r = 0; r < 4; r++) wr(6'h08 + 6'(r), 32'hC6A5_3900 ^ (32'(r) << 4));
    for (int r = 0; r < 4; r++) begin
      rd(6'h08 + 6'(r), d);
      chk("R10 mode fields", d, 32'hC6A5_3900 ^ (32'(r) << 4));
    end
    wr(6'h01, 32'hFFFF_FF2A);
    rd(6'h01, d); chk("R10 thresh", d, 32'h0000_002A);
    rd(6'h03, d); chk("R10 clear lo reads 0", d, 32'd0);
    rd(6'h04, d); chk("R10 clear hi reads 0", d, 32'd0);
    rd(6'h3F, d); chk("R10 unmapped", d, 32'd0);

    // sweep over level modes, floors and line patterns: R2 R5 R7 R8 R9
    for (int i = 0; i < 64; i++) begin
      sh_mode[i] = i[0] ? 2'b01 : 2'b00;
      sh_lvl[i]  = 8'((i * 5 + 3) % 8);
    end
    sh_mode[0] = 2'b01; sh_lvl[0] = 8'd7;
    push_cfg();
    sh_en = 1'b1; wr(6'h00, 32'd1);
    for (int p = 0; p < 60; p++) begin
      next_lfsr();
      sh_thr = 8'(p % 5);
      wr(6'h01, 32'(sh_thr));
      src = (p % 10 == 0) ? 64'hAAAA_AAAA_AAAA_AAAB : lfsr;
      settle(4);
      chk_state("R2 R5 R7 R8 R9 sweep");
    end

    // R7 ties: all equal urgency, all active high, line 0 active too (R9)
    for (int i = 0; i < 64; i++) begin sh_mode[i] = 2'b01; sh_lvl[i] = 8'd3; end
    push_cfg();
    sh_thr = 8'd0; wr(6'h01, 32'd0);
    src = '1;
    settle(4);
    chk_status("R7 tie lowest wins, R9", 32'd1);
    src[1] = 1'b0;
    settle(4);
    chk_status("R7 tie next line", 32'd2);
    sh_lvl[63] = 8'd4; push_cfg();
    settle(2);
    chk_status("R7 higher urgency wins", 32'd63);

    // R5 floor equal to urgency blocks
    wr(6'h01, 32'd4);
    settle(2);
    chk_status("R5 floor equal blocks", IDLE);
    wr(6'h01, 32'd3);
    settle(2);
    chk_status("R5 floor below passes", 32'd63);

    // R6 global enable
    wr(6'h00, 32'd0);
    settle(2);
    chk_status("R6 disabled", IDLE);
    wr(6'h00, 32'd1);
    settle(2);
    chk_status("R6 re-enabled", 32'd63);

    // R11 latency
    for (int i = 0; i < 64; i++) begin sh_mode[i] = 2'b01; sh_lvl[i] = 8'd0; end
    sh_lvl[9] = 8'd4;
    push_cfg();
    wr(6'h01, 32'd0);
    src = '0;
    settle(4);
    chk_status("R11 quiet before", IDLE);
    @(negedge clk); src[9] = 1'b1;
    settle(2);
    chk("R11 not after two edges", 32'(irq), 32'd0);
    settle(1);
    chk("R11 after third edge", 32'(irq), 32'd1);
    rd(6'h02, d); chk("R11 status", d, 32'd9);

    // R3 R4 edge latches
    for (int i = 0; i < 64; i++) begin sh_mode[i] = 2'b00; sh_lvl[i] = 8'd0; end
    sh_mode[5] = 2'b11;  sh_lvl[5]  = 8'd2;
    sh_mode[40] = 2'b10; sh_lvl[40] = 8'd3;
    sh_mode[53] = 2'b11; sh_lvl[53] = 8'd4;
    src = '0; src[40] = 1'b1;
    settle(4);
    push_cfg();
    settle(4);
    chk_status("R3 no edge yet", IDLE);
    src[5] = 1'b1; settle(5);
    chk_status("R3 rising latched", 32'd5);
    src[5] = 1'b0; settle(5);
    chk_status("R3 held after return", 32'd5);
    wr(6'h03, 32'h0000_0005); settle(2);
    chk_status("R4 no enable bit", 32'd5);
    wr(6'h03, 32'h0105_0000); settle(2);
    chk_status("R4 other group", 32'd5);
    wr(6'h04, 32'h0000_0105); settle(2);
    chk_status("R4 other half", 32'd5);
    wr(6'h03, 32'h0000_0105); settle(2);
    chk_status("R4 cleared", IDLE);
    src[40] = 1'b0; settle(5);
    chk_status("R3 falling latched", 32'd40);
    src[53] = 1'b1; settle(5);
    chk_status("R3 higher edge line", 32'd53);
    src[40] = 1'b1; src[53] = 1'b0; settle(5);
    chk_status("R3 opposite edges ignored", 32'd53);
    wr(6'h04, 32'h0105_0000); settle(2);
    chk_status("R4 upper group clear", 32'd40);
    wr(6'h04, 32'h0000_0108); settle(2);
    chk_status("R4 hi half clear", IDLE);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule